// File: doc/BRIEF.md
# Multithreaded Scoreboard Issue Scheduler

This block decides, every cycle, which of several hardware threads may send its next decoded instruction to one of four functional-unit groups: load/store, add/subtract, multiply/shuffle and logical. Each thread presents one decoded request (target unit, two source registers, one destination register). The thread keeps its own register scoreboard and its own writeback timing window. Readiness is judged inside each thread alone. A fixed-priority arbiter per unit then settles conflicts between threads, so up to four instructions leave in one cycle, one per unit.

When an instruction issues, its destination register becomes pending. A reservation is placed in the thread's timing window at a depth equal to the unit's latency. As reservations reach the head of the window, the block drives the writeback route for that thread: which unit's result goes to which register. The register file commits the write at the clock edge that ends that cycle, and the pending mark drops at the same edge. Each register file has a single write port, so a thread never holds two reservations for the same cycle.

Top module: `smt_issue_sched`

## Requirements
- R1: After reset no register of any thread is pending and the timing windows are empty. With idle inputs, `grant`, `unit_valid` and `wb_valid` are all low. A request naming any registers is granted at once.
- R2: A thread is granted only when its `req_valid` is high and none of its two sources or its destination is pending in that thread's own scoreboard. Otherwise it stalls, and the request may stay asserted.
- R3: A thread that issues in cycle c with latency L sees that destination pending in cycles c+1 to c+L. A dependent request is granted no earlier than cycle c+L+1.
- R4: A grant in cycle c puts `wb_valid`, `wb_unit` and `wb_dst` of that thread up in cycle c+L. The unit codes are 0 load/store, 1 add, 2 multiply/shuffle and 3 logical. The default latencies are 2, 1, 3 and 1 cycles.
- R5: A request whose writeback cycle is already reserved by an earlier instruction of the same thread stalls. A request whose writeback cycle is free is not held back.
- R6: Among ready threads asking for the same unit, the lowest thread index wins. The loser keeps its request and is granted once the higher-priority threads stop asking.
- R7: Ready threads that ask for four different units are all granted in the same cycle.
- R8: Each unit is granted to at most one thread per cycle.
- R9: A higher-priority thread that is not ready does not block a lower-priority ready thread that asks for the same unit. One thread's pending registers never stall another thread.
- R10: `unit_valid[u]` is high exactly when unit u is granted, and `unit_thread[u]` then gives the granted thread's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NTHREAD | Per-thread request present |
| req_unit | input | NTHREAD x 2 | Per-thread target unit code |
| req_src_a | input | NTHREAD x log2(NREG) | Per-thread first source register |
| req_src_b | input | NTHREAD x log2(NREG) | Per-thread second source register |
| req_dst | input | NTHREAD x log2(NREG) | Per-thread destination register |
| grant | output | NTHREAD | Per-thread issue grant this cycle |
| unit_valid | output | 4 | Per-unit issue this cycle |
| unit_thread | output | 4 x log2(NTHREAD) | Per-unit source thread select |
| wb_valid | output | NTHREAD | Per-thread writeback route valid |
| wb_unit | output | NTHREAD x 2 | Unit whose result goes to the thread's register file |
| wb_dst | output | NTHREAD x log2(NREG) | Register written at the end of this cycle |

## Verification
The bench targets the edges of the pending window. It checks that a dependent request stays blocked through the writeback cycle and is granted exactly one cycle later. A scoreboard that cleared one cycle early would let a stale operand through, and one that cleared late would waste a cycle. Tests that mix latencies probe the write-port rule in both directions. A window checked at the wrong depth would either let two writes into one cycle or stall an instruction whose slot is free. Priority tests confirm that a stalled high-priority thread neither starves a lower one nor loses its own request. They also confirm that one thread's pending register never blocks another thread.

// File: rtl/smt_sched_pkg.sv
package smt_sched_pkg;

    typedef enum logic [1:0] {
        FU_LSU = 2'd0,
        FU_ADD = 2'd1,
        FU_MUL = 2'd2,
        FU_LOG = 2'd3
    } fu_e;

    localparam int unsigned NUM_FU = 4;

    function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                            int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/smt_thread_ctl.sv
module smt_thread_ctl
    import smt_sched_pkg::*;
#(
    parameter int unsigned NREG    = 16,
    parameter int unsigned LAT_LSU = 2,
    parameter int unsigned LAT_ADD = 1,
    parameter int unsigned LAT_MUL = 3,
    parameter int unsigned LAT_LOG = 1,
    localparam int unsigned RW  = $clog2(NREG),
    localparam int unsigned WIN = max_of4(LAT_LSU, LAT_ADD, LAT_MUL, LAT_LOG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  fu_e           req_unit,
    input  logic [RW-1:0] src_a,
    input  logic [RW-1:0] src_b,
    input  logic [RW-1:0] dst,
    input  logic          grant,
    output logic          ready,
    output logic          wb_valid,
    output fu_e           wb_unit,
    output logic [RW-1:0] wb_dst
);

    typedef struct packed {
        logic          v;
        fu_e           unit;
        logic [RW-1:0] dst;
    } slot_t;

    typedef struct packed {
        logic [NREG-1:0]  pend;
        slot_t [WIN-1:0]  slot;
    } state_t;

    state_t state_d, state_q;
    int     lat_sel;
    logic   slot_free;
    logic   hazard;

    always_comb begin
        unique case (req_unit)
            FU_LSU:  lat_sel = int'(LAT_LSU);
            FU_ADD:  lat_sel = int'(LAT_ADD);
            FU_MUL:  lat_sel = int'(LAT_MUL);
            default: lat_sel = int'(LAT_LOG);
        endcase

        // The entry now at depth lat_sel lands where the new one would go.
        slot_free = 1'b1;
        for (int k = 1; k < int'(WIN); k++) begin
            if (k == lat_sel && state_q.slot[k].v) slot_free = 1'b0;
        end

        hazard = state_q.pend[src_a] | state_q.pend[src_b] | state_q.pend[dst];
        ready  = req_valid && !hazard && slot_free;

        state_d = state_q;
        for (int k = 0; k < int'(WIN) - 1; k++) begin
            state_d.slot[k] = state_q.slot[k+1];
        end
        state_d.slot[WIN-1] = '0;

        if (state_q.slot[0].v) state_d.pend[state_q.slot[0].dst] = 1'b0;

        if (grant) begin
            for (int k = 0; k < int'(WIN); k++) begin
                if (k == lat_sel - 1) begin
                    state_d.slot[k].v    = 1'b1;
                    state_d.slot[k].unit = req_unit;
                    state_d.slot[k].dst  = dst;
                end
            end
            state_d.pend[dst] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign wb_valid = state_q.slot[0].v;
    assign wb_unit  = state_q.slot[0].unit;
    assign wb_dst   = state_q.slot[0].dst;

endmodule

// File: rtl/smt_fu_arb.sv
module smt_fu_arb #(
    parameter int unsigned NT = 4,
    localparam int unsigned TW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic [NT-1:0] req,
    output logic [NT-1:0] gnt,
    output logic          valid,
    output logic [TW-1:0] idx
);

    always_comb begin
        gnt   = '0;
        valid = 1'b0;
        idx   = '0;
        // Walk from the lowest index upward; the first hit wins.
        for (int t = 0; t < int'(NT); t++) begin
            if (req[t] && !valid) begin
                valid  = 1'b1;
                gnt[t] = 1'b1;
                idx    = TW'(t);
            end
        end
    end

endmodule

// File: rtl/smt_issue_sched.sv
module smt_issue_sched
    import smt_sched_pkg::*;
#(
    parameter int unsigned NTHREAD = 4,
    parameter int unsigned NREG    = 16,
    parameter int unsigned LAT_LSU = 2,
    parameter int unsigned LAT_ADD = 1,
    parameter int unsigned LAT_MUL = 3,
    parameter int unsigned LAT_LOG = 1,
    localparam int unsigned TW = (NTHREAD > 1) ? $clog2(NTHREAD) : 1,
    localparam int unsigned RW = $clog2(NREG)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NTHREAD-1:0]             req_valid,
    input  logic [NTHREAD-1:0][1:0]        req_unit,
    input  logic [NTHREAD-1:0][RW-1:0]     req_src_a,
    input  logic [NTHREAD-1:0][RW-1:0]     req_src_b,
    input  logic [NTHREAD-1:0][RW-1:0]     req_dst,
    output logic [NTHREAD-1:0]             grant,
    output logic [NUM_FU-1:0]              unit_valid,
    output logic [NUM_FU-1:0][TW-1:0]      unit_thread,
    output logic [NTHREAD-1:0]             wb_valid,
    output logic [NTHREAD-1:0][1:0]        wb_unit,
    output logic [NTHREAD-1:0][RW-1:0]     wb_dst
);

    logic [NTHREAD-1:0]              thr_ready;
    logic [NUM_FU-1:0][NTHREAD-1:0]  unit_req;
    logic [NUM_FU-1:0][NTHREAD-1:0]  unit_gnt;

    for (genvar t = 0; t < NTHREAD; t++) begin : g_thr
        fu_e wb_unit_e;

        smt_thread_ctl #(
            .NREG    (NREG),
            .LAT_LSU (LAT_LSU),
            .LAT_ADD (LAT_ADD),
            .LAT_MUL (LAT_MUL),
            .LAT_LOG (LAT_LOG)
        ) u_thr (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_valid (req_valid[t]),
            .req_unit  (fu_e'(req_unit[t])),
            .src_a     (req_src_a[t]),
            .src_b     (req_src_b[t]),
            .dst       (req_dst[t]),
            .grant     (grant[t]),
            .ready     (thr_ready[t]),
            .wb_valid  (wb_valid[t]),
            .wb_unit   (wb_unit_e),
            .wb_dst    (wb_dst[t])
        );

        assign wb_unit[t] = wb_unit_e;
    end

    always_comb begin
        for (int u = 0; u < int'(NUM_FU); u++) begin
            for (int t = 0; t < int'(NTHREAD); t++) begin
                unit_req[u][t] = thr_ready[t] && (req_unit[t] == 2'(u));
            end
        end
    end

    for (genvar u = 0; u < NUM_FU; u++) begin : g_arb
        smt_fu_arb #(.NT(NTHREAD)) u_arb (
            .req   (unit_req[u]),
            .gnt   (unit_gnt[u]),
            .valid (unit_valid[u]),
            .idx   (unit_thread[u])
        );
    end

    always_comb begin
        grant = '0;
        for (int u = 0; u < int'(NUM_FU); u++) begin
            grant = grant | unit_gnt[u];
        end
    end

endmodule

// File: rtl/smt_sched_checker.sv
module smt_sched_checker #(
    parameter int unsigned NTHREAD = 4,
    parameter int unsigned NREG    = 16,
    parameter int unsigned LAT_LOG = 1,
    localparam int unsigned TW = (NTHREAD > 1) ? $clog2(NTHREAD) : 1,
    localparam int unsigned RW = $clog2(NREG)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NTHREAD-1:0]          req_valid,
    input logic [NTHREAD-1:0][1:0]     req_unit,
    input logic [NTHREAD-1:0][RW-1:0]  req_src_a,
    input logic [NTHREAD-1:0][RW-1:0]  req_src_b,
    input logic [NTHREAD-1:0][RW-1:0]  req_dst,
    input logic [NTHREAD-1:0]          grant,
    input logic [NTHREAD-1:0]          ready,
    input logic [3:0]                  unit_valid,
    input logic [3:0][TW-1:0]          unit_thread,
    input logic [NTHREAD-1:0]          wb_valid,
    input logic [NTHREAD-1:0][1:0]     wb_unit,
    input logic [NTHREAD-1:0][RW-1:0]  wb_dst
);

    logic [3:0][NTHREAD-1:0] per_unit;

    always_comb begin
        for (int u = 0; u < 4; u++) begin
            for (int t = 0; t < int'(NTHREAD); t++) begin
                per_unit[u][t] = grant[t] && (req_unit[t] == 2'(u));
            end
        end
    end

    for (genvar u = 0; u < 4; u++) begin : g_u
        p_one_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(per_unit[u]));

        p_unit_map_r10: assert property (@(posedge clk) disable iff (!rst_n)
            unit_valid[u] |-> (grant[unit_thread[u]] && req_unit[unit_thread[u]] == 2'(u)));
    end

    for (genvar t = 0; t < NTHREAD; t++) begin : g_t
        p_needs_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
            grant[t] |-> req_valid[t]);

        p_no_back_to_back_dep_r3: assert property (@(posedge clk) disable iff (!rst_n)
            grant[t] |=> !(grant[t] && (req_src_a[t] == $past(req_dst[t]) ||
                                        req_src_b[t] == $past(req_dst[t]) ||
                                        req_dst[t]   == $past(req_dst[t]))));

        p_logic_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (LAT_LOG == 1 && grant[t] && req_unit[t] == 2'd3) |=>
                (wb_valid[t] && wb_unit[t] == 2'd3 && wb_dst[t] == $past(req_dst[t])));

        for (genvar h = 0; h < t; h++) begin : g_hi
            p_fixed_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (ready[h] && ready[t] && req_unit[h] == req_unit[t]) |-> !grant[t]);
        end
    end

endmodule

bind smt_issue_sched smt_sched_checker #(
    .NTHREAD (NTHREAD),
    .NREG    (NREG),
    .LAT_LOG (LAT_LOG)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_unit    (req_unit),
    .req_src_a   (req_src_a),
    .req_src_b   (req_src_b),
    .req_dst     (req_dst),
    .grant       (grant),
    .ready       (thr_ready),
    .unit_valid  (unit_valid),
    .unit_thread (unit_thread),
    .wb_valid    (wb_valid),
    .wb_unit     (wb_unit),
    .wb_dst      (wb_dst)
);

// File: tb/smt_issue_sched_bench.sv
`timescale 1ns/1ps
module smt_issue_sched_bench;

    localparam int NT = 4;
    localparam int RW = 4;
    localparam int TW = 2;
    localparam int U_LSU = 0, U_ADD = 1, U_MUL = 2, U_LOG = 3;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NT-1:0]         req_valid = '0;
    logic [NT-1:0][1:0]    req_unit = '0;
    logic [NT-1:0][RW-1:0] req_src_a = '0;
    logic [NT-1:0][RW-1:0] req_src_b = '0;
    logic [NT-1:0][RW-1:0] req_dst = '0;
    logic [NT-1:0]         grant;
    logic [3:0]            unit_valid;
    logic [3:0][TW-1:0]    unit_thread;
    logic [NT-1:0]         wb_valid;
    logic [NT-1:0][1:0]    wb_unit;
    logic [NT-1:0][RW-1:0] wb_dst;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    smt_issue_sched u_smt_issue_sched (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_unit(req_unit),
        .req_src_a(req_src_a), .req_src_b(req_src_b), .req_dst(req_dst),
        .grant(grant), .unit_valid(unit_valid), .unit_thread(unit_thread),
        .wb_valid(wb_valid), .wb_unit(wb_unit), .wb_dst(wb_dst)
    );

    function automatic int lat_of(int u);
        case (u)
            U_LSU:   return 2;
            U_ADD:   return 1;
            U_MUL:   return 3;
            default: return 1;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic setreq(int t, int u, int a, int b, int d);
        req_valid[t] = 1'b1;
        req_unit[t]  = 2'(u);
        req_src_a[t] = RW'(a);
        req_src_b[t] = RW'(b);
        req_dst[t]   = RW'(d);
    endtask

    task automatic drop(int t);
        req_valid[t] = 1'b0;
    endtask

    task automatic drain();
        req_valid = '0;
        repeat (5) tick();
    endtask

    task automatic test_reset();
        #1;
        chk("R1 grant idle", int'(grant), 0);
        chk("R1 unit_valid idle", int'(unit_valid), 0);
        chk("R1 wb_valid idle", int'(wb_valid), 0);
        setreq(0, U_ADD, 15, 14, 13);
        #1;
        chk("R1 fresh registers free", int'(grant[0]), 1);
        drain();
    endtask

    task automatic test_latency();
        for (int u = 0; u < 4; u++) begin
            setreq(0, u, 0, 0, 10 + u);
            #1;
            chk("R4 issue", int'(grant[0]), 1);
            tick();
            drop(0);
            for (int k = 1; k <= lat_of(u); k++) begin
                #1;
                chk("R4 wb_valid timing", int'(wb_valid[0]), (k == lat_of(u)) ? 1 : 0);
                if (k == lat_of(u)) begin
                    chk("R4 wb_unit", int'(wb_unit[0]), u);
                    chk("R4 wb_dst", int'(wb_dst[0]), 10 + u);
                end
                tick();
            end
        end
        drain();
    endtask

    task automatic test_raw();
        setreq(0, U_MUL, 1, 2, 5);
        #1;
        chk("R3 producer issue", int'(grant[0]), 1);
        tick();
        setreq(0, U_ADD, 5, 1, 6);
        setreq(1, U_ADD, 5, 5, 5);
        #1;
        chk("R3 dependent stalls c+1", int'(grant[0]), 0);
        chk("R9 other thread not blocked", int'(grant[1]), 1);
        chk("R10 add unit from thread 1", int'(unit_thread[U_ADD]), 1);
        tick();
        drop(1);
        #1;
        chk("R3 dependent stalls c+2", int'(grant[0]), 0);
        tick();
        #1;
        chk("R3 dependent stalls c+3", int'(grant[0]), 0);
        chk("R4 mul route at c+3", int'(wb_valid[0]), 1);
        chk("R4 mul route dst", int'(wb_dst[0]), 5);
        tick();
        #1;
        chk("R3 dependent issues c+4", int'(grant[0]), 1);
        drain();
    endtask

    task automatic test_operands();
        setreq(0, U_LOG, 0, 0, 7);
        #1;
        chk("R2 logic issue", int'(grant[0]), 1);
        tick();
        setreq(0, U_LOG, 3, 7, 8);
        #1;
        chk("R2 second source pending", int'(grant[0]), 0);
        tick();
        #1;
        chk("R2 second source released", int'(grant[0]), 1);
        drain();
        setreq(0, U_ADD, 0, 0, 9);
        #1;
        chk("R2 add issue", int'(grant[0]), 1);
        tick();
        setreq(0, U_LOG, 1, 2, 9);
        #1;
        chk("R2 destination pending", int'(grant[0]), 0);
        tick();
        #1;
        chk("R2 destination released", int'(grant[0]), 1);
        drain();
    endtask

    task automatic test_slots();
        setreq(1, U_MUL, 0, 0, 3);
        #1;
        chk("R5 mul issue", int'(grant[1]), 1);
        tick();
        setreq(1, U_LSU, 0, 0, 4);
        #1;
        chk("R5 load clashes with mul slot", int'(grant[1]), 0);
        tick();
        #1;
        chk("R5 load issues next cycle", int'(grant[1]), 1);
        tick();
        drop(1);
        #1;
        chk("R5 mul writes first", int'(wb_unit[1]), U_MUL);
        chk("R5 mul dst", int'(wb_dst[1]), 3);
        tick();
        #1;
        chk("R5 load writes second", int'(wb_valid[1]), 1);
        chk("R5 load unit", int'(wb_unit[1]), U_LSU);
        drain();

        setreq(1, U_MUL, 0, 0, 3);
        #1;
        chk("R5 mul issue again", int'(grant[1]), 1);
        tick();
        setreq(1, U_ADD, 0, 0, 8);
        #1;
        chk("R5 free slot not held", int'(grant[1]), 1);
        tick();
        setreq(1, U_ADD, 0, 0, 9);
        #1;
        chk("R5 add clashes with mul slot", int'(grant[1]), 0);
        chk("R4 first add route", int'(wb_dst[1]), 8);
        tick();
        #1;
        chk("R5 add issues after clash", int'(grant[1]), 1);
        chk("R5 mul route beside add issue", int'(wb_dst[1]), 3);
        drain();
    endtask

    task automatic test_four_issue();
        setreq(0, U_LSU, 0, 0, 1);
        setreq(1, U_ADD, 0, 0, 1);
        setreq(2, U_MUL, 0, 0, 1);
        setreq(3, U_LOG, 0, 0, 1);
        #1;
        chk("R7 four grants", int'(grant), 15);
        chk("R10 all units busy", int'(unit_valid), 15);
        for (int u = 0; u < 4; u++) chk("R10 unit thread map", int'(unit_thread[u]), u);
        drain();
        setreq(0, U_LOG, 0, 0, 2);
        setreq(1, U_MUL, 0, 0, 2);
        setreq(2, U_ADD, 0, 0, 2);
        setreq(3, U_LSU, 0, 0, 2);
        #1;
        chk("R7 four grants rotated", int'(grant), 15);
        chk("R10 logic unit from thread 0", int'(unit_thread[U_LOG]), 0);
        chk("R10 load unit from thread 3", int'(unit_thread[U_LSU]), 3);
        drain();
    endtask

    task automatic test_priority();
        setreq(0, U_ADD, 0, 0, 1);
        setreq(2, U_ADD, 0, 0, 1);
        setreq(3, U_ADD, 0, 0, 1);
        #1;
        chk("R6 lowest index wins", int'(grant), 1);
        chk("R8 one add grant", int'(unit_valid), 2);
        tick();
        drop(0);
        #1;
        chk("R6 waiting thread 2 served", int'(grant), 4);
        chk("R10 add from thread 2", int'(unit_thread[U_ADD]), 2);
        tick();
        drop(2);
        #1;
        chk("R6 waiting thread 3 served", int'(grant), 8);
        drain();
    endtask

    initial begin
        repeat (3) tick();
        test_reset_pre();
        rst_n = 1'b1;
        tick();
        test_reset();
        test_latency();
        test_raw();
        test_operands();
        test_slots();
        test_four_issue();
        test_priority();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    task automatic test_reset_pre();
        #1;
        chk("R1 grant in reset", int'(grant), 0);
        chk("R1 wb_valid in reset", int'(wb_valid), 0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung, expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule